// File: doc/BRIEF.md
# Hysteretic PLL Lock Judge

This block decides whether a phase-locked loop is locked by watching the error pulses of its phase detector. Both the up and the down pulse are combined and passed through a synchronizer into a fast sampling clock domain. There, the width of each combined pulse is counted in sampling-clock ticks. When a pulse ends, its width is sorted into one of three classes: good (narrow), tolerated (middle) or bad (wide). A strobe marks the start of every phase detector cycle. If a cycle produced no pulse at all, that cycle is judged as a zero-width, good cycle when the next strobe arrives.

A run counter tracks consecutive good cycles while the loop is unlocked. A select input picks the required run length: a short run or a long run. Once the run is complete, an active-high lock flag is raised. The flag has asymmetric hysteresis. A wider clear threshold governs the locked state, so middle-width errors leave lock in place, and only one wide error drops it. The flag drives status logic elsewhere in the chip.

Top module: `pll_lock_judge`

## Requirements
- R1: `lock_o` is active high. An asserted `rst_n` (low) forces `lock_o` to 0 at once and clears the run count, even while locked.
- R2: With `long_run_i` = 0, `lock_o` rises after 3 consecutive good cycles and not after 2. A good cycle is one whose combined pulse width is below `SET_TICKS` ticks (default 6, so widths 0 to 5).
- R3: With `long_run_i` = 1, `lock_o` rises after 5 consecutive good cycles and not after 4.
- R4: While unlocked, any cycle whose width is `SET_TICKS` ticks or more resets the consecutive-good count to zero.
- R5: While locked, a single cycle whose width exceeds `CLR_TICKS` ticks (default 10, so 11 or more) clears `lock_o`.
- R6: While locked, widths from `SET_TICKS` to `CLR_TICKS` inclusive leave `lock_o` high.
- R7: The width is the number of sampling-clock ticks during which `err_up_i` OR `err_dn_i` is high. An up pulse followed directly by a down pulse, or overlapping with one, counts as one pulse of the combined length.
- R8: A phase detector cycle, delimited by one-tick `pd_tick_i` strobes, that contains no error pulse is judged as a good cycle of width zero.
- R9: The width counter saturates at `CLR_TICKS`+1, so a pulse longer than the counter range is still judged bad and never wraps to a smaller class.
- R10: The run counter saturates at the selected target. After lock is cleared, a complete new run of the selected length is needed to lock again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pd_tick_i | input | 1 | One-tick strobe at the start of each phase detector cycle (sampling-clock domain) |
| err_up_i | input | 1 | Phase detector up pulse (asynchronous) |
| err_dn_i | input | 1 | Phase detector down pulse (asynchronous) |
| long_run_i | input | 1 | 0: 3 good cycles to lock, 1: 5 good cycles to lock |
| lock_o | output | 1 | Lock flag, active high |

## Verification
The bench uses the default thresholds of 6 and 10 ticks, run lengths of 3 and 5, and a two-stage synchronizer. With these values, every class boundary (5, 6, 10, 11) can be reached with short pulses. A 40-tick pulse exceeds the 4-bit width counter, so a counter that wrapped would misclassify it as a middle width, which makes saturation observable. The short runs keep lock, clear and relock sequences to a few dozen cycles, so the random phase switches between run lengths and crosses each threshold many times.

// File: rtl/pld_pkg.sv
package pld_pkg;
  typedef enum logic [1:0] {
    ERR_GOOD = 2'd0,
    ERR_MID  = 2'd1,
    ERR_BAD  = 2'd2
  } err_class_e;
endpackage

// File: rtl/pld_rst_sync.sv
module pld_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/pld_width_meter.sv
module pld_width_meter #(
  parameter int SYNC_STAGES = 2,
  parameter int SAT_TICKS   = 11,
  parameter int WID_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             tick_i,
  output logic             evt_o,
  output logic [WID_W-1:0] wid_o
);
  localparam logic [WID_W-1:0] SAT_V = WID_W'(SAT_TICKS);

  // combined error, synchronized through a generated flop chain
  logic [SYNC_STAGES:0] chain;
  assign chain[0] = up_i | dn_i;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s+1] <= 1'b0;
      else        chain[s+1] <= chain[s];
    end
  end

  logic             err_s, err_d_q, rise, fall;
  logic [WID_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             judged_q, judged_d;
  logic             evt_q, evt_d;
  logic [WID_W-1:0] wid_q, wid_d;

  assign err_s = chain[SYNC_STAGES];
  assign rise  = err_s & ~err_d_q;
  assign fall  = ~err_s & err_d_q;

  always_comb begin
    cnt_en = err_s;
    cnt_d  = cnt_q;
    if (rise)                cnt_d = WID_W'(1);
    else if (cnt_q != SAT_V) cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    judged_d = judged_q;
    if (tick_i)    judged_d = 1'b0;
    else if (fall) judged_d = 1'b1;
    evt_d = fall | (tick_i & ~judged_q);
    wid_d = fall ? cnt_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_d_q  <= 1'b0;
      judged_q <= 1'b1;
      evt_q    <= 1'b0;
      wid_q    <= '0;
    end else begin
      err_d_q  <= err_s;
      judged_q <= judged_d;
      evt_q    <= evt_d;
      wid_q    <= wid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign evt_o = evt_q;
  assign wid_o = wid_q;

  // R9
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_s && err_d_q && cnt_q == SAT_V) |=> (cnt_q == SAT_V));

  // R8
  idle_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !judged_q && !fall) |=> (evt_q && wid_q == '0));
endmodule

// File: rtl/pld_err_classify.sv
module pld_err_classify
  import pld_pkg::*;
#(
  parameter int SET_TICKS = 6,
  parameter int CLR_TICKS = 10,
  parameter int WID_W     = 4
) (
  input  logic [WID_W-1:0] wid_i,
  output err_class_e       cls_o
);
  localparam logic [WID_W-1:0] SET_V = WID_W'(SET_TICKS);
  localparam logic [WID_W-1:0] CLR_V = WID_W'(CLR_TICKS);

  always_comb begin
    if (wid_i < SET_V)      cls_o = ERR_GOOD;
    else if (wid_i > CLR_V) cls_o = ERR_BAD;
    else                    cls_o = ERR_MID;
  end
endmodule

// File: rtl/pld_lock_fsm.sv
module pld_lock_fsm
  import pld_pkg::*;
#(
  parameter int SHORT_RUN = 3,
  parameter int LONG_RUN  = 5,
  parameter int RUN_W     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_i,
  input  err_class_e cls_i,
  input  logic       long_sel_i,
  output logic       lock_o
);
  localparam logic [RUN_W-1:0] SHORT_V = RUN_W'(SHORT_RUN);
  localparam logic [RUN_W-1:0] LONG_V  = RUN_W'(LONG_RUN);

  logic [RUN_W-1:0] run_q, run_d, target;
  logic [RUN_W:0]   run_inc;
  logic             lock_q, lock_d;
  logic             upd_en;

  assign target  = long_sel_i ? LONG_V : SHORT_V;
  assign run_inc = {1'b0, run_q} + 1'b1;
  assign upd_en  = evt_i;

  always_comb begin
    run_d  = run_q;
    lock_d = lock_q;
    if (lock_q) begin
      if (cls_i == ERR_BAD) begin
        lock_d = 1'b0;
        run_d  = '0;
      end
    end else if (cls_i == ERR_GOOD) begin
      if (run_inc >= {1'b0, target}) begin
        lock_d = 1'b1;
        run_d  = target;
      end else begin
        run_d = run_inc[RUN_W-1:0];
      end
    end else begin
      run_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (upd_en) begin
      run_q  <= run_d;
      lock_q <= lock_d;
    end
  end

  assign lock_o = lock_q;

  // R2
  rise_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(evt_i && cls_i == ERR_GOOD));

  // R4
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && evt_i && cls_i != ERR_GOOD) |=> (run_q == '0 && !lock_q));

  // R5
  wide_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && evt_i && cls_i == ERR_BAD) |=> !lock_q);

  // R6
  mid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && evt_i && cls_i != ERR_BAD) |=> lock_q);

  // R10
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LONG_V);
endmodule

// File: rtl/pll_lock_judge.sv
module pll_lock_judge
  import pld_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SET_TICKS   = 6,
  parameter int CLR_TICKS   = 10,
  parameter int SHORT_RUN   = 3,
  parameter int LONG_RUN    = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_tick_i,
  input  logic err_up_i,
  input  logic err_dn_i,
  input  logic long_run_i,
  output logic lock_o
);
  localparam int SAT_TICKS = CLR_TICKS + 1;
  localparam int WID_W     = $clog2(SAT_TICKS + 1);
  localparam int RUN_W     = $clog2(LONG_RUN + 1);

  logic             srst_n;
  logic             evt;
  logic [WID_W-1:0] wid;
  err_class_e       cls;

  pld_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  pld_width_meter #(
    .SYNC_STAGES (SYNC_STAGES),
    .SAT_TICKS   (SAT_TICKS),
    .WID_W       (WID_W)
  ) u_meter (
    .clk    (clk),
    .rst_n  (srst_n),
    .up_i   (err_up_i),
    .dn_i   (err_dn_i),
    .tick_i (pd_tick_i),
    .evt_o  (evt),
    .wid_o  (wid)
  );

  pld_err_classify #(
    .SET_TICKS (SET_TICKS),
    .CLR_TICKS (CLR_TICKS),
    .WID_W     (WID_W)
  ) u_cls (
    .wid_i (wid),
    .cls_o (cls)
  );

  pld_lock_fsm #(
    .SHORT_RUN (SHORT_RUN),
    .LONG_RUN  (LONG_RUN),
    .RUN_W     (RUN_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (srst_n),
    .evt_i      (evt),
    .cls_i      (cls),
    .long_sel_i (long_run_i),
    .lock_o     (lock_o)
  );
endmodule

// File: tb/pll_lock_judge_bench.sv
module pll_lock_judge_bench;
  localparam int SET_T = 6;
  localparam int CLR_T = 10;

  logic clk = 1'b0;
  logic rst_n, tick, up, dn, sel;
  logic lock;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  bit lock_m;
  int run_m;
  bit pend_zero;

  always #2.5 clk = ~clk;

  pll_lock_judge #(
    .SYNC_STAGES (2),
    .SET_TICKS   (SET_T),
    .CLR_TICKS   (CLR_T),
    .SHORT_RUN   (3),
    .LONG_RUN    (5)
  ) u_pll_lock_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pd_tick_i  (tick),
    .err_up_i   (up),
    .err_dn_i   (dn),
    .long_run_i (sel),
    .lock_o     (lock)
  );

  function automatic int class_of(int w);
    if (w < SET_T) return 0;
    if (w > CLR_T) return 2;
    return 1;
  endfunction

  function automatic int target_of(bit s);
    return s ? 5 : 3;
  endfunction

  task automatic model_judge(int w);
    int c = class_of(w);
    if (lock_m) begin
      if (c == 2) begin lock_m = 1'b0; run_m = 0; end
    end else if (c == 0) begin
      run_m++;
      if (run_m >= target_of(sel)) begin lock_m = 1'b1; run_m = target_of(sel); end
    end else begin
      run_m = 0;
    end
  endtask

  task automatic check(string req);
    checks++;
    if (lock !== lock_m) begin
      errors++;
      $display("FAIL %s: lock_o=%0b expected %0b at %0t", req, lock, lock_m, $time);
    end
  endtask

  // one phase detector cycle: strobe, gap, pulse of w ticks, settle gap
  // mode 0: up only, 1: down only, 2: up then down with a one-tick overlap
  task automatic pd_cycle(int w, int mode, string req);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
    for (int i = 0; i < w; i++) begin
      up = (mode == 0) || (mode == 2 && i <= w / 2);
      dn = (mode == 1) || (mode == 2 && i >= w / 2);
      @(negedge clk);
    end
    up = 1'b0;
    dn = 1'b0;
    repeat (10) @(negedge clk);
    if (pend_zero) begin model_judge(0); pend_zero = 1'b0; end
    if (w > 0) model_judge(w);
    else       pend_zero = 1'b1;
    check(req);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    lock_m = 1'b0; run_m = 0; pend_zero = 1'b0;
    @(negedge clk);
    checks++;
    if (lock !== 1'b0) begin
      errors++;
      $display("FAIL R1: lock_o=%0b expected 0 in reset", lock);
    end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; up = 1'b0; dn = 1'b0; sel = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    do_reset();

    // R2: short run, boundary width 5 is still good
    sel = 1'b0;
    pd_cycle(3, 0, "R2 first good");
    pd_cycle(1, 1, "R2 second good, no lock yet");
    pd_cycle(5, 0, "R2 third good locks");
    // R6: widths 6 and 10 and a split pulse keep lock
    pd_cycle(6, 0, "R6 width at set threshold");
    pd_cycle(10, 1, "R6 width at clear threshold");
    pd_cycle(8, 2, "R6 split middle pulse");
    // R7: split pulse of 11 combined ticks clears
    pd_cycle(11, 2, "R7 combined up/down width 11 clears");
    // R4/R3: long run interrupted by a middle width
    sel = 1'b1;
    pd_cycle(2, 0, "R4 good 1");
    pd_cycle(2, 1, "R4 good 2");
    pd_cycle(4, 0, "R4 good 3");
    pd_cycle(6, 0, "R4 middle resets run");
    for (int k = 0; k < 4; k++) pd_cycle(3, 0, "R3 four goods after reset of run");
    pd_cycle(3, 0, "R3 fifth good locks");
    // R9: very long pulse still bad
    pd_cycle(40, 0, "R9 saturated width clears");
    // R8/R10: idle cycles count as good; full run needed again
    sel = 1'b0;
    pd_cycle(0, 0, "R8 idle 1");
    pd_cycle(0, 0, "R8 idle 2");
    pd_cycle(0, 0, "R10 relock needs full run");
    pd_cycle(0, 0, "R8 idle cycles lock");
    // R1: reset while locked
    do_reset();
    pd_cycle(0, 0, "R1 after reset unlocked");

    // random phase
    for (int n = 0; n < 400; n++) begin
      int w, mode, pick;
      if (($urandom % 16) == 0) sel = $urandom % 2;
      pick = $urandom % 10;
      if (pick < 6)      w = $urandom % SET_T;
      else if (pick < 8) w = SET_T + ($urandom % (CLR_T - SET_T + 1));
      else               w = CLR_T + 1 + ($urandom % 30);
      mode = (w >= 2) ? ($urandom % 3) : ($urandom % 2);
      pd_cycle(w, mode, "R2/R3 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule